// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gating Controller

This block sits between a memory controller's active-low chip-enable and two banks of battery-backed static RAM. While supply power is reported valid, a single bank-select input sends the incoming chip-enable to exactly one of two conditioned, active-low chip-enable outputs. An external comparator reports supply health as a digital power-valid flag. The block synchronises this flag and uses it to decide when both banks must be write-protected.

When power is lost and no access is running, both outputs go inactive at once. When an access is running, the bank that was being accessed keeps following the chip-enable until that access ends. A cycle counter caps this grace period at a fixed time, 150 µs by default. After it ends, both outputs stay high until power has been reported valid without a break for a set number of cycles and the chip-enable is idle. A tolerance-select input picks 5% or 10% supply tolerance. It goes out, registered, as a mode bit for the external detector.

Top module: `pf_ce_guard`

## Requirements
- R1: While reset is held, and after it is released, both chip-enable outputs are high and the tolerance mode output is 0. The block starts write-protected.
- R2: While passing, bankSel = 0 makes ceOutN[0] follow chipEnN with ceOutN[1] high. bankSel = 1 makes ceOutN[1] follow chipEnN with ceOutN[0] high. At most one output is ever low.
- R3: powerValidRaw (1 = valid) passes through two flops. A change on it is acted upon at the third rising clock edge after the change.
- R4: If chipEnN is high at the edge where the synchronised flag shows power-fail, both outputs go high and stay high whatever chipEnN does afterwards.
- R5: If chipEnN is low at the edge where power-fail is seen, the bank selected at that edge keeps following chipEnN and the other output stays high. Later changes of bankSel have no effect on this.
- R6: Once chipEnN returns high during that grace period, both outputs go high. A later chipEnN falling edge reaches neither output.
- R7: If chipEnN is still low TIMEOUT_CYC edges after the power-fail edge, both outputs are forced high at that edge.
- R8: Write-protect is left only at an edge where the synchronised flag has been valid at VALID_HOLD consecutive earlier edges and is still valid, and chipEnN is high. Any invalid sample restarts the count.
- R9: tolModeOut equals tolSel delayed by one clock.
- R10: TIMEOUT_CYC is derived as CLK_FREQ_HZ / 1,000,000 × TIMEOUT_US, which gives 15000 cycles (150 µs) at the 100 MHz default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, enters write-protect |
| powerValidRaw | input | 1 | Asynchronous power-valid flag from the comparator, 1 = valid |
| tolSel | input | 1 | Tolerance select, 0 = 5%, 1 = 10% |
| chipEnN | input | 1 | Incoming active-low chip-enable |
| bankSel | input | 1 | Bank select, 0 = bank 0, 1 = bank 1 |
| ceOutN | output | 2 | Conditioned active-low chip-enables, bit b drives bank b |
| tolModeOut | output | 1 | Registered tolerance mode to the external detector |

## Verification
The bench builds the block with CLK_FREQ_HZ = 2,000,000, TIMEOUT_US = 10 and VALID_HOLD = 4. This makes the grace-period limit 20 cycles, so a held chip-enable can be run into the forced write-protect and the exact edge counted. The short hold window lets the bench place a one-cycle dropout inside the power-valid count and see the exit delayed. It also lets the bench hold chip-enable low when the count completes and see that exit is blocked.

// File: rtl/pf_ce_pkg.sv
package pf_ce_pkg;

  localparam int NUM_BANKS = 2;

  typedef enum logic [1:0] {
    ST_PROTECT = 2'd0,
    ST_PASS    = 2'd1,
    ST_DRAIN   = 2'd2
  } guardState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic passEn;     // route chipEnN by live bankSel
    logic drainEn;    // route chipEnN to the captured bank only
    logic latchBank;  // capture bankSel this edge
  } ceStrobe_t;

endpackage

// File: rtl/pf_ce_datapath.sv
module pf_ce_datapath
  import pf_ce_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 powerValidRaw,
  input  logic                 tolSel,
  input  logic                 chipEnN,
  input  logic                 bankSel,
  input  ceStrobe_t            strobe,
  output logic                 pvSync,
  output logic [NUM_BANKS-1:0] ceOutN,
  output logic                 tolModeOut
);

  logic pvMeta;
  logic drainBank;

  // two-flop synchronizer for the comparator flag
  always_ff @(posedge clk) begin
    if (rst) begin
      pvMeta <= 1'b0;
      pvSync <= 1'b0;
    end else begin
      pvMeta <= powerValidRaw;
      pvSync <= pvMeta;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tolModeOut <= 1'b0;
    else     tolModeOut <= tolSel;
  end

  always_ff @(posedge clk) begin
    if (rst)                   drainBank <= 1'b0;
    else if (strobe.latchBank) drainBank <= bankSel;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic passHit;
    logic drainHit;
    always_comb begin
      passHit   = strobe.passEn  && (bankSel   == 1'(b));
      drainHit  = strobe.drainEn && (drainBank == 1'(b));
      ceOutN[b] = (passHit || drainHit) ? chipEnN : 1'b1;
    end
  end

  // R2
  oneBank_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ceOutN));

  // R4
  protectHigh_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.passEn && !strobe.drainEn) |-> (ceOutN == '1));

  // R5
  bankHeld_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strobe.drainEn) && strobe.drainEn) |-> $stable(drainBank));

endmodule

// File: rtl/pf_ce_control.sv
module pf_ce_control
  import pf_ce_pkg::*;
#(
  parameter int TIMEOUT_CYC = 15000,
  parameter int VALID_HOLD  = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pvSync,
  input  logic      chipEnN,
  output ceStrobe_t strobe
);

  localparam int TO_W   = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int HOLD_W = $clog2(VALID_HOLD + 1);

  guardState_t      state, nextState;
  logic [TO_W-1:0]  toCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic             toLast;
  logic             holdDone;

  always_comb begin
    toLast   = (toCnt == TO_W'(TIMEOUT_CYC - 1));
    holdDone = (holdCnt == HOLD_W'(VALID_HOLD));
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_PROTECT: if (pvSync && holdDone && chipEnN) nextState = ST_PASS;
      ST_PASS:    if (!pvSync) nextState = chipEnN ? ST_PROTECT : ST_DRAIN;
      ST_DRAIN:   if (chipEnN || toLast) nextState = ST_PROTECT;
      default:    nextState = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_PROTECT;
    else     state <= nextState;
  end

  // grace-period counter, runs only while draining
  always_ff @(posedge clk) begin
    if (rst || state != ST_DRAIN) toCnt <= '0;
    else if (!toLast)             toCnt <= toCnt + 1'b1;
  end

  // consecutive power-valid counter, saturating
  always_ff @(posedge clk) begin
    if (rst || state != ST_PROTECT || !pvSync) holdCnt <= '0;
    else if (!holdDone)                        holdCnt <= holdCnt + 1'b1;
  end

  always_comb begin
    strobe.passEn    = (state == ST_PASS);
    strobe.drainEn   = (state == ST_DRAIN);
    strobe.latchBank = (state == ST_PASS) && !pvSync && !chipEnN;
  end

  // R4
  failIdle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PASS && !pvSync && chipEnN) |=> (state == ST_PROTECT));

  // R7
  drainBound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN && toLast) |=> (state == ST_PROTECT));

  // R6
  drainStay_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && state == ST_DRAIN && $past(state) == ST_DRAIN) |-> !$past(chipEnN));

  // R8
  exitGate_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && state == ST_PASS && $past(state) == ST_PROTECT)
      |-> ($past(holdCnt) == HOLD_W'(VALID_HOLD) && $past(chipEnN) && $past(pvSync)));

endmodule

// File: rtl/pf_ce_guard.sv
module pf_ce_guard
  import pf_ce_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int TIMEOUT_US  = 150,
  parameter int VALID_HOLD  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       powerValidRaw,
  input  logic       tolSel,
  input  logic       chipEnN,
  input  logic       bankSel,
  output logic [1:0] ceOutN,
  output logic       tolModeOut
);

  // R10: grace period in cycles
  localparam int TIMEOUT_CYC = (CLK_FREQ_HZ / 1_000_000) * TIMEOUT_US;

  ceStrobe_t strobe;
  logic      pvSync;

  pf_ce_control #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .VALID_HOLD  (VALID_HOLD)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .pvSync  (pvSync),
    .chipEnN (chipEnN),
    .strobe  (strobe)
  );

  pf_ce_datapath dp_i (
    .clk           (clk),
    .rst           (rst),
    .powerValidRaw (powerValidRaw),
    .tolSel        (tolSel),
    .chipEnN       (chipEnN),
    .bankSel       (bankSel),
    .strobe        (strobe),
    .pvSync        (pvSync),
    .ceOutN        (ceOutN),
    .tolModeOut    (tolModeOut)
  );

  // R9
  tolDelay_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tolModeOut == $past(tolSel)));

endmodule

// File: tb/pf_ce_guard_tb_top.sv
module pf_ce_guard_tb_top;

  localparam int TB_FREQ = 2_000_000;
  localparam int TB_US   = 10;
  localparam int TB_HOLD = 4;
  localparam int TB_TO   = (TB_FREQ / 1_000_000) * TB_US;  // R10

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic powerValidRaw = 1'b0;
  logic tolSel = 1'b0;
  logic chipEnN = 1'b1;
  logic bankSel = 1'b0;
  logic [1:0] ceOutN;
  logic tolModeOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pf_ce_guard #(
    .CLK_FREQ_HZ (TB_FREQ),
    .TIMEOUT_US  (TB_US),
    .VALID_HOLD  (TB_HOLD)
  ) dut_i (
    .clk (clk), .rst (rst), .powerValidRaw (powerValidRaw), .tolSel (tolSel),
    .chipEnN (chipEnN), .bankSel (bankSel), .ceOutN (ceOutN), .tolModeOut (tolModeOut)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 protect, 1 pass, 2 drain
  int  mState = 0;
  int  holdC = 0;
  int  toC = 0;
  bit  s1 = 0, s2 = 0, mBank = 0, tolQ = 0;

  always @(posedge clk) begin
    if (rst) begin
      mState = 0; holdC = 0; toC = 0; s1 = 0; s2 = 0; mBank = 0; tolQ = 0;
    end else begin
      case (mState)
        0: begin
          if (s2 && holdC == TB_HOLD && chipEnN) begin mState = 1; holdC = 0; end
          else if (!s2) holdC = 0;
          else if (holdC < TB_HOLD) holdC++;
        end
        1: if (!s2) begin
          if (!chipEnN) begin mState = 2; mBank = bankSel; toC = 0; end
          else mState = 0;
        end
        default: begin
          if (chipEnN || toC == TB_TO - 1) begin mState = 0; toC = 0; end
          else toC++;
        end
      endcase
      s2 = s1; s1 = powerValidRaw; tolQ = tolSel;
    end
  end

  function automatic logic [1:0] expOut();
    logic [1:0] e = 2'b11;
    if (mState == 1) e[bankSel] = chipEnN;
    else if (mState == 2) e[mBank] = chipEnN;
    return e;
  endfunction

  // per-cycle comparison
  always @(negedge clk) begin
    #2;
    if (!rst && !done) begin
      check(mState == 1 ? "R2" : (mState == 2 ? "R5" : "R4"), ceOutN, expOut());
      check("R9", {1'b0, tolModeOut}, {1'b0, tolQ});
    end
  end

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic powerUp();
    powerValidRaw = 1'b1; chipEnN = 1'b1; tolSel = ~tolSel;
    stepN(3 + TB_HOLD + 2);
  endtask

  initial begin
    int n;
    stepN(3);
    #1 check("R1", ceOutN, 2'b11);
    check("R1", {1'b0, tolModeOut}, 2'b00);
    rst = 1'b0;
    stepN(2);
    #1 check("R1", ceOutN, 2'b11);

    // R8: power-up with a one-sample dropout and a blocked exit
    @(negedge clk) powerValidRaw = 1'b1;
    stepN(3); powerValidRaw = 1'b0;
    stepN(1); powerValidRaw = 1'b1;
    stepN(4); chipEnN = 1'b0;
    #1 check("R8", ceOutN, 2'b11);
    stepN(2); chipEnN = 1'b1;
    stepN(1); chipEnN = 1'b0;
    #1 check("R8", ceOutN, 2'b10);

    // R2: routing patterns
    stepN(1); bankSel = 1'b1;
    #1 check("R2", ceOutN, 2'b01);
    stepN(1); chipEnN = 1'b1;
    #1 check("R2", ceOutN, 2'b11);
    stepN(1); bankSel = 1'b0; chipEnN = 1'b0; tolSel = 1'b1;
    #1 check("R2", ceOutN, 2'b10);
    stepN(1); chipEnN = 1'b1;

    // R4: fail while idle, later chip-enable ignored
    stepN(1); powerValidRaw = 1'b0;
    stepN(3); chipEnN = 1'b0;
    #1 check("R4", ceOutN, 2'b11);
    stepN(3);
    #1 check("R4", ceOutN, 2'b11);
    chipEnN = 1'b1;
    stepN(1); powerUp();

    // R5 / R6: fail mid-access on bank 1
    bankSel = 1'b1; chipEnN = 1'b0; powerValidRaw = 1'b0;
    stepN(4); bankSel = 1'b0;
    #1 check("R5", ceOutN, 2'b01);
    stepN(1); chipEnN = 1'b1;
    stepN(1); chipEnN = 1'b0;
    #1 check("R6", ceOutN, 2'b11);
    stepN(2);
    #1 check("R6", ceOutN, 2'b11);
    chipEnN = 1'b1;
    stepN(1); powerUp();

    // R3 / R7 / R10: held access runs into the timeout
    bankSel = 1'b0; chipEnN = 1'b0; powerValidRaw = 1'b0;
    n = 0;
    while (n < 100) begin
      @(posedge clk); n++;
      @(negedge clk); #1;
      if (ceOutN == 2'b11) break;
    end
    check("R7", n[1:0], 2'(3 + TB_TO));
    checks++;
    if (n != 3 + TB_TO) begin
      errors++;
      $display("FAIL R10/R3: actual %0d edges expected %0d", n, 3 + TB_TO);
    end
    chipEnN = 1'b1;
    stepN(1); powerUp();
    chipEnN = 1'b0;
    #1 check("R2", ceOutN, 2'b10);
    stepN(2); chipEnN = 1'b1;
    stepN(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule